// File: doc/BRIEF.md
# Expansion ROM Window Base Register with Programmable Size

This block holds the configuration-space base register for an expansion ROM window and decides whether a memory read address falls inside that window. The window size is not fixed at design time. A separate setup register is loaded only from the local side, for example by a serial-ROM loader or a local processor. Its bits pick which base bits the host may write. A cleared high setup bit switches the whole window off.

The host side writes and reads the base register through its own configuration port. A memory-space enable input and a read address feed a combinational decoder. Its single output flags reads that must be steered to the ROM interface. Both write ports carry per-byte enables.

Top module: `rom_window_bar`

## Requirements
- R1: Base bit 0 is the decode enable. `rom_hit` can be 1 only when the stored bit 0 is 1 and `mem_en` is 1.
- R2: Base bits 11:1 ignore every write and always read as 0.
- R3: For each position k in 12..23, base bit k takes written data only while setup bit k is 1. While setup bit k is 0, base bit k ignores writes and reads as 0.
- R4: While setup bit 24 is 0, the base register reads as all zeros, bit 0 included, and `rom_hit` stays 0.
- R5: While setup bit 24 is 1, base bits 31:24 are always writable.
- R6: The address hits when `addr[31:12]` equals the stored base on every writable position. Positions 12..23 whose setup bit is 0 are ignored. The window therefore spans 4 KB when setup bits 23:12 are all 1, and 16 MB when they are all 0.
- R7: After reset, the setup register and the base register are both 0 and `rom_hit` is 0.
- R8: When a setup write makes a base bit read-only, that base bit is cleared on the same clock edge.
- R9: Each write port updates only the bytes whose enable bit is set. Byte n covers bits 8n+7:8n. The setup register reads back all 32 bits as they were written.
- R10: A register write becomes visible on the read port after the next rising clock edge. `rom_hit` follows `addr`, `mem_en` and the current register state without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_we | input | 1 | Local-side write strobe for the setup register |
| setup_be | input | 4 | Byte enables for the setup write |
| setup_wdata | input | 32 | Setup write data |
| setup_rdata | output | 32 | Setup register contents |
| bar_we | input | 1 | Host-side write strobe for the base register |
| bar_be | input | 4 | Byte enables for the base write |
| bar_wdata | input | 32 | Base write data |
| bar_rdata | output | 32 | Base register read value |
| mem_en | input | 1 | Memory-space enable from the command register |
| addr | input | 32 | Memory read address to decode |
| rom_hit | output | 1 | Address falls in the enabled ROM window |

## Verification
The bench drives a full-ones base write under a partial size mask, so the reserved bits and the non-writable size bits must come back as 0. A design that masked with the wrong setup bits would let size bits leak into the readback. The bench then shrinks the setup register so that base bits turn read-only. A design that masks only on later host writes would keep stale base bits set, and the decoder would use them. Addresses are chosen that differ from the base only in size bits, and also in a fixed bit, to separate a correct don't-care comparison from a full compare. Clearing setup bit 24 must blank the register and force a miss even when bit 0 was set before.

// File: rtl/rombar_pkg.sv
package rombar_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned N_BYTES = REG_W / 8;
  localparam int unsigned MIN_LG  = 12;
  localparam int unsigned MAX_LG  = 24;

  // Mask of base bits the host may write, given the setup word.
  function automatic logic [REG_W-1:0] host_wr_mask(input logic [REG_W-1:0] setup,
                                                    input int unsigned lo,
                                                    input int unsigned hi);
    logic [REG_W-1:0] m;
    m = '0;
    if (setup[hi]) begin
      m[0] = 1'b1;
      for (int unsigned i = lo; i < hi; i++) m[i] = setup[i];
      for (int unsigned i = hi; i < REG_W; i++) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Merge enabled bytes of a write into an old word.
  function automatic logic [REG_W-1:0] lane_merge(input logic [REG_W-1:0] old_v,
                                                  input logic [REG_W-1:0] new_v,
                                                  input logic [N_BYTES-1:0] be);
    logic [REG_W-1:0] r;
    for (int unsigned b = 0; b < N_BYTES; b++)
      r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/rombar_setup_reg.sv
module rombar_setup_reg
  import rombar_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  localparam int unsigned NB = W / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [NB-1:0] be,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  setup_nxt,
  output logic [W-1:0]  setup_q
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign setup_nxt[b*8 +: 8] = (we && be[b]) ? wdata[b*8 +: 8] : setup_q[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) setup_q <= '0;
    else        setup_q <= setup_nxt;
  end
endmodule

// File: rtl/rombar_base_reg.sv
module rombar_base_reg
  import rombar_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned LO = MIN_LG,
  parameter int unsigned HI = MAX_LG,
  localparam int unsigned NB = W / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [NB-1:0] be,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  setup_nxt,
  output logic [W-1:0]  mask_nxt,
  output logic [W-1:0]  base_q
);
  logic [W-1:0] merged;

  assign mask_nxt = host_wr_mask(setup_nxt, LO, HI);
  assign merged   = we ? lane_merge(base_q, wdata, be) : base_q;

  // Masking with the next setup value clears newly read-only bits on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= merged & mask_nxt;
  end
endmodule

// File: rtl/rombar_decode.sv
module rombar_decode
  import rombar_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned LO = MIN_LG,
  parameter int unsigned HI = MAX_LG
) (
  input  logic [W-1:0] base_q,
  input  logic [W-1:0] setup_q,
  input  logic         mem_en,
  input  logic [W-1:0] addr,
  output logic         addr_match,
  output logic         hit
);
  logic [W-1:0] cmp_mask;
  logic [W-1:0] diff;

  assign cmp_mask   = host_wr_mask(setup_q, LO, HI) & ~((W'(1) << LO) - W'(1));
  assign diff       = (addr ^ base_q) & cmp_mask;
  assign addr_match = (diff == '0);
  assign hit        = setup_q[HI] & base_q[0] & mem_en & addr_match;
endmodule

// File: rtl/rom_window_bar.sv
module rom_window_bar
  import rombar_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned LO = MIN_LG,
  parameter int unsigned HI = MAX_LG,
  localparam int unsigned NB = W / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          setup_we,
  input  logic [NB-1:0] setup_be,
  input  logic [W-1:0]  setup_wdata,
  output logic [W-1:0]  setup_rdata,
  input  logic          bar_we,
  input  logic [NB-1:0] bar_be,
  input  logic [W-1:0]  bar_wdata,
  output logic [W-1:0]  bar_rdata,
  input  logic          mem_en,
  input  logic [W-1:0]  addr,
  output logic          rom_hit
);
  logic [W-1:0] setup_nxt;
  logic [W-1:0] setup_q;
  logic [W-1:0] mask_nxt;
  logic [W-1:0] base_q;
  logic         addr_match;

  rombar_setup_reg #(.W(W)) u_setup (
    .clk(clk), .rst_n(rst_n), .we(setup_we), .be(setup_be), .wdata(setup_wdata),
    .setup_nxt(setup_nxt), .setup_q(setup_q)
  );

  rombar_base_reg #(.W(W), .LO(LO), .HI(HI)) u_base (
    .clk(clk), .rst_n(rst_n), .we(bar_we), .be(bar_be), .wdata(bar_wdata),
    .setup_nxt(setup_nxt), .mask_nxt(mask_nxt), .base_q(base_q)
  );

  rombar_decode #(.W(W), .LO(LO), .HI(HI)) u_dec (
    .base_q(base_q), .setup_q(setup_q), .mem_en(mem_en), .addr(addr),
    .addr_match(addr_match), .hit(rom_hit)
  );

  assign setup_rdata = setup_q;
  assign bar_rdata   = base_q;
endmodule

// File: rtl/rom_window_bar_chk.sv
module rom_window_bar_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned LO = 12,
  parameter int unsigned HI = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         setup_we,
  input logic         bar_we,
  input logic         mem_en,
  input logic [W-1:0] setup_rdata,
  input logic [W-1:0] bar_rdata,
  input logic         rom_hit,
  input logic         addr_match
);
  // R1
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit |-> (bar_rdata[0] && mem_en && addr_match));
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_rdata[LO-1:1] == '0);
  // R3
  size_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_rdata[HI-1:LO] & ~setup_rdata[HI-1:LO]) == '0);
  // R4
  disabled_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_rdata[HI] |-> (bar_rdata == '0 && !rom_hit));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bar_we && !setup_we) |=> $stable(bar_rdata) && $stable(setup_rdata));
endmodule

bind rom_window_bar rom_window_bar_chk #(.W(W), .LO(LO), .HI(HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .setup_we(setup_we), .bar_we(bar_we), .mem_en(mem_en),
  .setup_rdata(setup_rdata), .bar_rdata(bar_rdata), .rom_hit(rom_hit),
  .addr_match(addr_match)
);

// File: tb/rom_window_bar_tb.sv
module rom_window_bar_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_we = 1'b0;
  logic [3:0]  setup_be = '0;
  logic [31:0] setup_wdata = '0;
  logic [31:0] setup_rdata;
  logic        bar_we = 1'b0;
  logic [3:0]  bar_be = '0;
  logic [31:0] bar_wdata = '0;
  logic [31:0] bar_rdata;
  logic        mem_en = 1'b0;
  logic [31:0] addr = '0;
  logic        rom_hit;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [31:0] m_setup = '0;
  logic [31:0] m_bar = '0;

  always #10 clk = ~clk;

  rom_window_bar u_dut (
    .clk(clk), .rst_n(rst_n), .setup_we(setup_we), .setup_be(setup_be),
    .setup_wdata(setup_wdata), .setup_rdata(setup_rdata), .bar_we(bar_we),
    .bar_be(bar_be), .bar_wdata(bar_wdata), .bar_rdata(bar_rdata),
    .mem_en(mem_en), .addr(addr), .rom_hit(rom_hit)
  );

  function automatic bit may_write(input logic [31:0] s, input int k);
    if (!s[24]) return 1'b0;
    if (k == 0 || k >= 24) return 1'b1;
    if (k >= 12) return s[k];
    return 1'b0;
  endfunction

  function automatic logic [31:0] apply_be(input logic [31:0] o, input logic [31:0] n,
                                           input logic [3:0] be);
    logic [31:0] r = o;
    for (int k = 0; k < 32; k++) if (be[k/8]) r[k] = n[k];
    return r;
  endfunction

  function automatic bit exp_hit(input logic [31:0] s, input logic [31:0] b,
                                 input logic me, input logic [31:0] a);
    if (!(s[24] && b[0] && me)) return 1'b0;
    for (int k = 12; k < 32; k++)
      if (may_write(s, k) && a[k] != b[k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Drive at negedge, check combinational/state outputs, then advance the model at posedge.
  task automatic step(input logic swe, input logic [3:0] sbe, input logic [31:0] sd,
                      input logic bwe, input logic [3:0] bbe, input logic [31:0] bd,
                      input logic me, input logic [31:0] a);
    logic [31:0] ns;
    logic [31:0] nb;
    setup_we = swe; setup_be = sbe; setup_wdata = sd;
    bar_we = bwe; bar_be = bbe; bar_wdata = bd;
    mem_en = me; addr = a;
    #1;
    check("R6", {31'd0, rom_hit}, {31'd0, exp_hit(m_setup, m_bar, me, a)});
    check("R3", bar_rdata, m_bar);
    check("R9", setup_rdata, m_setup);
    @(posedge clk);
    ns = swe ? apply_be(m_setup, sd, sbe) : m_setup;
    nb = bwe ? apply_be(m_bar, bd, bbe) : m_bar;
    for (int k = 0; k < 32; k++) if (!may_write(ns, k)) nb[k] = 1'b0;
    m_setup = ns;
    m_bar = nb;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mem_en = 1'b1;
    #1;
    // R7 reset state
    check("R7", bar_rdata, 32'h0);
    check("R7", setup_rdata, 32'h0);
    check("R7", {31'd0, rom_hit}, 32'h0);

    // 1 MB window: setup bits 24 and 23:20
    step(1, 4'hF, 32'h01F0_0000, 0, 4'h0, 0, 1, 0);
    step(0, 4'h0, 0, 1, 4'hF, 32'hFFFF_FFFF, 1, 0);
    // R2 R5: reserved and size bits clear, high bits written
    check("R2", bar_rdata & 32'h0000_0FFE, 32'h0);
    check("R5", bar_rdata, 32'hFFF0_0001);
    // R10: pending write not visible before the edge
    bar_we = 1'b1; bar_be = 4'hF; bar_wdata = 32'h1230_0001; #1;
    check("R10", bar_rdata, 32'hFFF0_0001);
    bar_we = 1'b0; #1;
    // R6 size bits don't-care; R10 hit follows address with no delay
    addr = 32'hFFF8_1234; mem_en = 1'b1; #1;
    check("R6", {31'd0, rom_hit}, 32'd1);
    addr = 32'hFFE0_0000; #1;
    check("R10", {31'd0, rom_hit}, 32'd0);
    // R1 memory enable gates the hit
    addr = 32'hFFF8_1234; mem_en = 1'b0; #1;
    check("R1", {31'd0, rom_hit}, 32'd0);
    // R8 R9: byte 2 of setup cleared, bits 23:20 become read-only
    step(1, 4'h4, 32'h0000_0000, 0, 4'h0, 0, 1, 32'hFFF8_1234);
    check("R8", bar_rdata, 32'hFF00_0001);
    check("R9", setup_rdata, 32'h0100_0000);
    // R4 disable then re-enable: register blank, no hit
    step(1, 4'h8, 32'h0000_0000, 0, 4'h0, 0, 1, 32'hFF00_0000);
    check("R4", bar_rdata, 32'h0);
    check("R4", {31'd0, rom_hit}, 32'd0);
    step(1, 4'h8, 32'h0100_0000, 0, 4'h0, 0, 1, 32'hFF00_0000);
    check("R4", bar_rdata, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] sd;
      logic [31:0] ad;
      sd = $urandom;
      if ($urandom_range(3) != 0) sd[24] = 1'b1;
      if ($urandom_range(1) == 0) sd[23:12] = 12'hFFF << $urandom_range(12);
      ad = $urandom_range(1) ? (m_bar ^ ($urandom & 32'h00FF_FFFF)) : $urandom;
      step($urandom_range(5) == 0, 4'($urandom), sd,
           $urandom_range(2) == 0, 4'($urandom), $urandom,
           $urandom_range(4) != 0, ad);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule